// File: doc/BRIEF.md
# Flash Access Security Gate

This block sits in front of the flash and EEPROM controllers and judges each memory operation request before any memory cycle starts. A request carries an operation code, a sector index and a source tag (device programmer or JTAG). The gate checks the request against two pieces of configuration. One is a device-wide security bit. The other is a set of per-sector erase-protect bits. It then answers with either a one-cycle grant, which starts the memory cycle, or a one-cycle block pulse.

Both pieces of configuration are copied from a non-volatile image while reset is held. When the device is secured, only a full chip erase gets through. Reads, verifies, byte programs and sector erases are refused from either source. Once a full chip erase reports completion, the gate wipes the security bit and every protect bit, and it emits a one-cycle clear command so the non-volatile image can be rewritten blank. Protect bits refuse sector erases aimed at their own sector only.

Requests arrive on a valid/ready interface. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While `req_valid` is high and `req_ready` is low, the requester holds the operation, sector and source fields steady. `req_ready` drops for as long as a granted program or erase is running, and rises again once `mem_done` is seen. Read and verify grants never apply back-pressure.

Top module: `flash_access_gate`

## Requirements
- R1: While `rst_n` is low, the security bit and protect bits are loaded from `img_secure` and `img_protect` on each clock edge. On the first cycle after reset, `gnt`, `blk`, `busy` and `cfg_clear` are low and `req_ready` is high. After reset the security bit never becomes set.
- R2: Operation codes are 0 read, 1 verify, 2 byte program, 3 sector erase and 4 full chip erase. Source 0 is the device programmer and 1 is JTAG. When the device is unsecured, a read, verify or byte program to any sector index below `NSECT` is granted. `mem_op`, `mem_sect` and `mem_src` then carry the request's fields in the grant cycle.
- R3: While secured, read, verify, byte program and sector erase are blocked, whichever source sends them.
- R4: A full chip erase is granted whether or not the device is secured, and for any sector index.
- R5: While unsecured, a sector erase is blocked if that sector's protect bit is set and granted if it is clear. Protect bit i belongs to sector index i.
- R6: A request whose operation code is 5, 6 or 7 is blocked. So is any read, verify, program or sector erase whose sector index is `NSECT` or above.
- R7: A granted program, sector erase or chip erase raises `busy` in its grant cycle. `req_ready` then stays low until the cycle after `mem_done` is sampled high while busy. Read and verify grants leave `busy` low, and `mem_done` has no effect while not busy.
- R8: A blocked request starts no memory cycle (`gnt` stays low), leaves `busy` unchanged and keeps `req_ready` high.
- R9: When `mem_done` ends a full chip erase, `cfg_clear` pulses for exactly the next cycle. From that cycle on, the security bit and all protect bits are clear. Nothing is cleared while the chip erase is still running.
- R10: Each accepted request produces exactly one of `gnt` or `blk`, one clock after acceptance. Neither pulse appears in a cycle without an acceptance on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration image is loaded while low |
| img_secure | input | 1 | Security bit from the non-volatile image |
| img_protect | input | NSECT | Per-sector erase-protect bits from the non-volatile image |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Gate can take a request this cycle |
| req_op | input | 3 | Operation code (0 read, 1 verify, 2 program, 3 sector erase, 4 chip erase) |
| req_sect | input | SECT_W | Target sector index |
| req_src | input | 1 | Request source (0 programmer, 1 JTAG) |
| gnt | output | 1 | One-cycle grant; starts the memory cycle |
| blk | output | 1 | One-cycle refusal pulse |
| mem_op | output | 3 | Operation of the granted cycle |
| mem_sect | output | SECT_W | Sector of the granted cycle |
| mem_src | output | 1 | Source of the granted cycle |
| busy | output | 1 | A granted program or erase is in progress |
| mem_done | input | 1 | Memory controller reports the running program or erase finished |
| cfg_clear | output | 1 | One-cycle command to rewrite the security and protect image blank |

## Verification
The bench targets requests that differ in a single field from a granted one. Examples are a sector erase to a protected sector next to an unprotected one, a sector index one past the last sector, and reserved operation codes. A gate that decoded the index or the protect vector wrongly would grant an erase it should refuse, or the reverse. A secured device is sent every operation from both sources, so a gate that exempted JTAG or verify would emit a grant where a block is due. A stray `mem_done` while idle, and a chip erase that runs for several cycles before completing, expose designs that clear the configuration on the start of the erase or on any `mem_done` pulse. Such a design would grant a sector erase too early or raise `cfg_clear` at the wrong time.

// File: rtl/fag_pkg.sv
package fag_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_READ       = 3'd0,
    OP_VERIFY     = 3'd1,
    OP_PROG       = 3'd2,
    OP_SECT_ERASE = 3'd3,
    OP_CHIP_ERASE = 3'd4
  } op_e;

  // Operations that occupy the memory for a while and so hold busy.
  function automatic logic op_holds_busy(logic [OP_W-1:0] op);
    return (op == OP_PROG) || (op == OP_SECT_ERASE) || (op == OP_CHIP_ERASE);
  endfunction

  function automatic logic op_is_chip(logic [OP_W-1:0] op);
    return op == OP_CHIP_ERASE;
  endfunction

endpackage

// File: rtl/fag_cfg_store.sv
module fag_cfg_store #(
  parameter int NSECT = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             img_secure,
  input  logic [NSECT-1:0] img_protect,
  input  logic             wipe,
  output logic             secure,
  output logic [NSECT-1:0] protect,
  output logic             wiped
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      secure <= img_secure;
      wiped  <= 1'b0;
    end else begin
      wiped <= wipe;
      if (wipe) secure <= 1'b0;
    end
  end

  for (genvar g = 0; g < NSECT; g++) begin : g_prot
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)    bit_q <= img_protect[g];
      else if (wipe) bit_q <= 1'b0;
    end
    assign protect[g] = bit_q;
  end

  // R1: outside reset nothing may set the security bit again
  assert_secure_never_rises_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(secure));

endmodule

// File: rtl/fag_policy.sv
module fag_policy
  import fag_pkg::*;
#(
  parameter int NSECT  = 12,
  parameter int SECT_W = 4
) (
  input  logic [OP_W-1:0]   op,
  input  logic [SECT_W-1:0] sect,
  input  logic              secure,
  input  logic [NSECT-1:0]  protect,
  output logic              allow
);

  logic             in_range;
  logic [NSECT-1:0] prot_shift;
  logic             locked;

  always_comb begin
    in_range   = int'(sect) < NSECT;
    prot_shift = protect >> sect;
    locked     = prot_shift[0];
    case (op)
      OP_CHIP_ERASE:               allow = 1'b1;
      OP_READ, OP_VERIFY, OP_PROG: allow = !secure && in_range;
      OP_SECT_ERASE:               allow = !secure && in_range && !locked;
      default:                     allow = 1'b0;
    endcase
  end

endmodule

// File: rtl/fag_issue.sv
module fag_issue
  import fag_pkg::*;
#(
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [OP_W-1:0]   req_op,
  input  logic [SECT_W-1:0] req_sect,
  input  logic              req_src,
  input  logic              allow,
  input  logic              mem_done,
  output logic              req_ready,
  output logic              gnt,
  output logic              blk,
  output logic [OP_W-1:0]   mem_op,
  output logic [SECT_W-1:0] mem_sect,
  output logic              mem_src,
  output logic              busy,
  output logic              chip_finish
);

  logic accept;
  logic chip_pend;

  assign req_ready   = !busy;
  assign accept      = req_valid && req_ready;
  assign chip_finish = busy && mem_done && chip_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt       <= 1'b0;
      blk       <= 1'b0;
      busy      <= 1'b0;
      chip_pend <= 1'b0;
      mem_op    <= '0;
      mem_sect  <= '0;
      mem_src   <= 1'b0;
    end else begin
      gnt <= accept && allow;
      blk <= accept && !allow;
      if (accept && allow) begin
        mem_op   <= req_op;
        mem_sect <= req_sect;
        mem_src  <= req_src;
        if (op_holds_busy(req_op)) begin
          busy      <= 1'b1;
          chip_pend <= op_is_chip(req_op);
        end
      end else if (busy && mem_done) begin
        busy      <= 1'b0;
        chip_pend <= 1'b0;
      end
    end
  end

  // R10: a verdict is either a grant or a refusal, never both
  assert_one_verdict_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt && blk));

  // R8: a refusal never changes the busy state
  assert_blk_keeps_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blk |-> $stable(busy));

  // R7: busy is held until completion is reported
  assert_busy_until_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_done) |=> busy);

endmodule

// File: rtl/flash_access_gate.sv
module flash_access_gate
  import fag_pkg::*;
#(
  parameter int NSECT = 12,
  localparam int SECT_W = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              img_secure,
  input  logic [NSECT-1:0]  img_protect,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OP_W-1:0]   req_op,
  input  logic [SECT_W-1:0] req_sect,
  input  logic              req_src,
  output logic              gnt,
  output logic              blk,
  output logic [OP_W-1:0]   mem_op,
  output logic [SECT_W-1:0] mem_sect,
  output logic              mem_src,
  output logic              busy,
  input  logic              mem_done,
  output logic              cfg_clear
);

  logic             secure;
  logic [NSECT-1:0] protect;
  logic             allow;
  logic             chip_finish;

  fag_cfg_store #(.NSECT(NSECT)) i_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .img_secure  (img_secure),
    .img_protect (img_protect),
    .wipe        (chip_finish),
    .secure      (secure),
    .protect     (protect),
    .wiped       (cfg_clear)
  );

  fag_policy #(.NSECT(NSECT), .SECT_W(SECT_W)) i_policy (
    .op      (req_op),
    .sect    (req_sect),
    .secure  (secure),
    .protect (protect),
    .allow   (allow)
  );

  fag_issue #(.SECT_W(SECT_W)) i_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_sect    (req_sect),
    .req_src     (req_src),
    .allow       (allow),
    .mem_done    (mem_done),
    .req_ready   (req_ready),
    .gnt         (gnt),
    .blk         (blk),
    .mem_op      (mem_op),
    .mem_sect    (mem_sect),
    .mem_src     (mem_src),
    .busy        (busy),
    .chip_finish (chip_finish)
  );

  // R3 / R4: a device that was secured at the decision edge only grants chip erase
  assert_secured_only_chip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |-> (!$past(secure) || (mem_op == OP_CHIP_ERASE)));

  // R5: a granted sector erase targeted a sector that was unprotected
  assert_no_protected_erase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt && (mem_op == OP_SECT_ERASE)) |->
      ((($past(protect) >> mem_sect) & NSECT'(1)) == '0));

  // R9: the clear command only follows a completion report
  assert_clear_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clear |-> $past(busy && mem_done));

endmodule

// File: tb/test_flash_access_gate.sv
module test_flash_access_gate;

  localparam int NSECT = 12;
  localparam int SW    = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             img_secure;
  logic [NSECT-1:0] img_protect;
  logic             req_valid;
  logic             req_ready;
  logic [2:0]       req_op;
  logic [SW-1:0]    req_sect;
  logic             req_src;
  logic             gnt, blk;
  logic [2:0]       mem_op;
  logic [SW-1:0]    mem_sect;
  logic             mem_src;
  logic             busy;
  logic             mem_done;
  logic             cfg_clear;

  always #4ns clk = ~clk;

  flash_access_gate #(.NSECT(NSECT)) i_flash_access_gate (
    .clk(clk), .rst_n(rst_n), .img_secure(img_secure), .img_protect(img_protect),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_sect(req_sect),
    .req_src(req_src), .gnt(gnt), .blk(blk), .mem_op(mem_op), .mem_sect(mem_sect),
    .mem_src(mem_src), .busy(busy), .mem_done(mem_done), .cfg_clear(cfg_clear)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done_run = 0;

  // reference model state
  bit             m_sec;
  bit [NSECT-1:0] m_prot;
  bit             m_busy, m_pend;
  bit             e_gnt, e_blk, e_clr;
  bit [2:0]       e_op;
  bit [SW-1:0]    e_sect;
  bit             e_src;
  string          e_tag = "R10";
  bit             m_live = 0, m_was_rst = 0, m_first = 0;

  function automatic bit ref_allow(int op, int sect, bit sec, bit [NSECT-1:0] prot);
    if (op == 4) return 1'b1;
    if (op > 4) return 1'b0;
    if (sec) return 1'b0;
    if (sect >= NSECT) return 1'b0;
    if (op == 3) return !prot[sect];
    return 1'b1;
  endfunction

  function automatic string ref_tag(int op, int sect, bit sec);
    if (op == 4) return "R4";
    if (op > 4 || sect >= NSECT) return "R6";
    if (sec) return "R3";
    if (op == 3) return "R5";
    return "R2";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = img_secure; m_prot = img_protect;
      m_busy = 0; m_pend = 0; e_gnt = 0; e_blk = 0; e_clr = 0;
      m_live = 0; m_was_rst = 1; m_first = 0;
    end else begin
      m_first = m_was_rst; m_was_rst = 0; m_live = 1;
      e_gnt = 0; e_blk = 0; e_clr = 0;
      if (m_busy) begin
        if (mem_done) begin
          m_busy = 0;
          if (m_pend) begin m_sec = 0; m_prot = '0; e_clr = 1; end
          m_pend = 0;
        end
      end else if (req_valid) begin
        e_tag = ref_tag(int'(req_op), int'(req_sect), m_sec);
        if (ref_allow(int'(req_op), int'(req_sect), m_sec, m_prot)) begin
          e_gnt = 1; e_op = req_op; e_sect = req_sect; e_src = req_src;
          if (req_op == 3'd2 || req_op == 3'd3 || req_op == 3'd4) begin
            m_busy = 1; m_pend = (req_op == 3'd4);
          end
        end else begin
          e_blk = 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && m_live) begin
      string vt;
      vt = (e_gnt || e_blk) ? e_tag : "R10";
      if (m_first) begin
        chk("R1", "gnt after reset", 32'(gnt), 32'(e_gnt));
        chk("R1", "blk after reset", 32'(blk), 32'(e_blk));
        chk("R1", "busy after reset", 32'(busy), 32'(m_busy));
        chk("R1", "cfg_clear after reset", 32'(cfg_clear), 32'(e_clr));
        chk("R1", "req_ready after reset", 32'(req_ready), 32'(!m_busy));
      end else begin
        chk(vt, "gnt", 32'(gnt), 32'(e_gnt));
        chk(vt, "blk", 32'(blk), 32'(e_blk));
        chk("R10", "gnt and blk together", 32'(gnt && blk), 32'd0);
        if (e_gnt && gnt) begin
          chk(e_tag, "mem_op", 32'(mem_op), 32'(e_op));
          if (e_op != 3'd4) chk(e_tag, "mem_sect", 32'(mem_sect), 32'(e_sect));
          chk(e_tag, "mem_src", 32'(mem_src), 32'(e_src));
        end
        chk(e_blk ? "R8" : "R7", "busy", 32'(busy), 32'(m_busy));
        chk(e_blk ? "R8" : "R7", "req_ready", 32'(req_ready), 32'(!m_busy));
        chk("R9", "cfg_clear", 32'(cfg_clear), 32'(e_clr));
      end
    end
  end

  task automatic summary_and_end();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_run) begin
      fails++;
      $display("FAIL R7 watchdog actual=%0d expected=finish before 150000", cyc);
      done_run = 1;
      summary_and_end();
    end
  end

  task automatic do_reset(input bit sec, input bit [NSECT-1:0] prot);
    @(negedge clk);
    rst_n = 0; img_secure = sec; img_protect = prot;
    req_valid = 0; mem_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send(input int op, input int sect, input bit src);
    @(negedge clk);
    req_valid = 1; req_op = 3'(op); req_sect = SW'(sect); req_src = src;
    forever begin
      automatic bit acc = req_ready;
      @(negedge clk);
      if (acc) break;
    end
    req_valid = 0;
  endtask

  task automatic finish_op(input int wait_cycles);
    repeat (wait_cycles) @(negedge clk);
    mem_done = 1;
    @(negedge clk);
    mem_done = 0;
  endtask

  initial begin
    rst_n = 0; img_secure = 0; img_protect = '0;
    req_valid = 0; req_op = 0; req_sect = 0; req_src = 0; mem_done = 0;

    // unsecured, sectors 0, 2 and 9 protected (R2, R5, R6, R7, R9)
    do_reset(1'b0, 12'b0010_0000_0101);
    send(0, 0, 0);  send(0, 11, 1);  send(1, 5, 0);
    send(2, 7, 1);  finish_op(3);
    send(3, 0, 0);  send(3, 2, 1);
    send(3, 1, 0);  finish_op(2);
    send(0, 12, 0); send(1, 15, 1); send(6, 3, 0); send(7, 0, 0); send(5, 1, 1);
    send(3, 12, 0);
    @(negedge clk); mem_done = 1; @(negedge clk); mem_done = 0;   // idle done ignored
    send(4, 15, 1); finish_op(5);
    send(3, 0, 0);  finish_op(1);
    send(3, 9, 1);  finish_op(1);

    // secured, all sectors protected (R3, R4, R8, R9)
    do_reset(1'b1, '1);
    send(0, 0, 0);  send(0, 3, 1);  send(1, 1, 1);  send(1, 1, 0);
    send(2, 4, 0);  send(2, 4, 1);  send(3, 5, 1);  send(3, 5, 0);  send(5, 0, 0);
    send(4, 0, 1);  finish_op(4);
    send(0, 3, 1);  send(3, 5, 0);  finish_op(1);

    // mixed random traffic with occasional resets
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (i % 500 == 498) begin
        rst_n = 0; img_secure = 1'($urandom % 2); img_protect = NSECT'($urandom);
      end else if (i % 500 == 499) begin
        rst_n = 0;
      end else begin
        rst_n = 1;
      end
      req_valid = 1'($urandom % 2);
      req_op    = 3'($urandom % 8);
      if (req_op == 3'd4 && ($urandom % 4) != 0) req_op = 3'd0;
      req_sect  = SW'($urandom);
      req_src   = 1'($urandom % 2);
      mem_done  = (($urandom % 4) == 0);
    end
    @(negedge clk);
    req_valid = 0; mem_done = 0; rst_n = 1;
    repeat (4) @(negedge clk);
    done_run = 1;
    summary_and_end();
  end

endmodule